// File: doc/BRIEF.md
# Serial Audio Left-Channel Byte Capture

This block sits behind an external serial audio converter. It takes in the converter's serial data, bit clock and channel-select clock, all running asynchronously to a faster system clock, and pulls one 24-bit two's-complement word out of every left-channel slot. The three serial lines are synchronized into the system clock domain. Bit clock and channel-select transitions are found by edge detection there, and data is taken on each rising bit-clock edge.

Only the top byte of each completed left word is kept. It is presented on a registered output with a ready flag. The consumer pulses an accept input to drop the flag. A word that completes before the previous byte was accepted replaces that byte, and the flag stays set. Right-channel slots, bits beyond the 24th and incomplete left slots never produce a sample.

Top module: `serial_adc_capture`

## Requirements
- R1: While and just after the synchronous reset, `sample_ready_o` is 0 and `sample_o` is 0.
- R2: Bits are taken MSB first on rising bit-clock edges. `sample_o` equals the first 8 bits received after a rising edge of `frame_clk_i`, which are bits 23..16 of the 24-bit word, with the first bit at the output's bit 7.
- R3: Bits received while `frame_clk_i` is low (right channel) change neither `sample_o` nor `sample_ready_o`.
- R4: Once the 24th bit of a left slot has been received, `sample_ready_o` goes to 1 and `sample_o` carries the new byte.
- R5: While `sample_ready_o` is 1 and no new left word completes, `sample_o` holds its value.
- R6: A one-cycle pulse on `sample_taken_i` while `sample_ready_o` is 1 clears `sample_ready_o`, unless a new word completes in the same cycle.
- R7: A left word that completes while the previous byte is unaccepted replaces that byte, and `sample_ready_o` stays 1.
- R8: Bits after the 24th in one left slot are ignored. The bit count stops at 24, and a long left slot yields exactly one sample.
- R9: After reset, no word is captured until `frame_clk_i` has been seen rising. A channel-select clock that is already high when reset is released does not count as a rising edge.
- R10: A left slot that ends with fewer than 24 bits produces no sample. The next rising `frame_clk_i` restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data_i | input | 1 | Serial audio data, asynchronous |
| bit_clk_i | input | 1 | Serial bit clock, asynchronous |
| frame_clk_i | input | 1 | Channel select: high = left slot, asynchronous |
| sample_taken_i | input | 1 | Consumer accepts the presented byte |
| sample_o | output | KEEP_W (8) | Top byte of the last completed left word |
| sample_ready_o | output | 1 | A byte is waiting to be accepted |

## Verification
The hardest states to reach from the ports are the ones where the channel-select clock gives no usable start of frame. One is a clock that is already high as reset is released. The other is a left slot that is cut short or runs past 24 bits. The stimulus holds `frame_clk_i` high through reset and clocks a full word, then sends slots of 10 and 30 bits. It checks that neither produces a spurious byte and that the following normal slot still decodes correctly. The overwrite case is reached by sending two complete frames in a row with no accept pulse between them.

// File: rtl/sac_pkg.sv
package sac_pkg;
  parameter int unsigned SAC_WORD_W = 24;
  parameter int unsigned SAC_KEEP_W = 8;
  parameter int unsigned SAC_SYNC_N = 2;
endpackage

// File: rtl/sac_sync.sv
module sac_sync #(
  parameter int unsigned STAGES = sac_pkg::SAC_SYNC_N
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/sac_edge.sv
module sac_edge #(
  parameter int unsigned WARM = sac_pkg::SAC_SYNC_N + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic          prev_q;
  logic [WARM-1:0] warm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      warm_q <= '0;
    end else begin
      prev_q <= level_i;
      warm_q <= {warm_q[WARM-2:0], 1'b1};
    end
  end

  // Edges are suppressed until the synchronizer and prev register hold real input.
  assign rise_o = warm_q[WARM-1] & level_i & ~prev_q;
endmodule

// File: rtl/sac_shifter.sv
module sac_shifter #(
  parameter int unsigned WORD_W = sac_pkg::SAC_WORD_W,
  parameter int unsigned KEEP_W = sac_pkg::SAC_KEEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_rise_i,
  input  logic              frame_lvl_i,
  input  logic              frame_rise_i,
  input  logic              din_i,
  output logic              word_done_o,
  output logic [KEEP_W-1:0] top_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take_bit;

  assign take_bit = bit_rise_i & frame_lvl_i & ~frame_rise_i & (cnt_q != FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q     <= '0;
      cnt_q       <= FULL;
      word_done_o <= 1'b0;
    end else begin
      word_done_o <= take_bit & (cnt_q == LAST);
      if (frame_rise_i) begin
        cnt_q <= '0;
      end else if (take_bit) begin
        shreg_q <= {shreg_q[WORD_W-2:0], din_i};
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign top_o = shreg_q[WORD_W-1 -: KEEP_W];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL); // R8
  AST_RIGHT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bit_rise_i && !frame_lvl_i && !frame_rise_i) |=> $stable(shreg_q)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    word_done_o |=> !word_done_o); // R8
endmodule

// File: rtl/sac_hold.sv
module sac_hold #(
  parameter int unsigned KEEP_W = sac_pkg::SAC_KEEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [KEEP_W-1:0] byte_i,
  input  logic              taken_i,
  output logic [KEEP_W-1:0] sample_o,
  output logic              ready_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      ready_o  <= 1'b0;
    end else if (done_i) begin
      sample_o <= byte_i;
      ready_o  <= 1'b1;
    end else if (taken_i) begin
      ready_o  <= 1'b0;
    end
  end

  AST_LOAD_SETS: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (ready_o && sample_o == $past(byte_i))); // R4
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ready_o && taken_i && !done_i) |=> !ready_o); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !done_i) |=> $stable(sample_o)); // R5
endmodule

// File: rtl/serial_adc_capture.sv
module serial_adc_capture #(
  parameter int unsigned WORD_W = sac_pkg::SAC_WORD_W,
  parameter int unsigned KEEP_W = sac_pkg::SAC_KEEP_W,
  parameter int unsigned SYNC_N = sac_pkg::SAC_SYNC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data_i,
  input  logic              bit_clk_i,
  input  logic              frame_clk_i,
  input  logic              sample_taken_i,
  output logic [KEEP_W-1:0] sample_o,
  output logic              sample_ready_o
);
  localparam int unsigned WARM = SYNC_N + 1;

  logic data_lvl, bclk_lvl, frame_lvl;
  logic bclk_rise, frame_rise;
  logic word_done;
  logic [KEEP_W-1:0] top_byte;

  sac_sync #(.STAGES(SYNC_N)) i_sync_data  (.clk(clk), .rst(rst), .async_i(ser_data_i),  .level_o(data_lvl));
  sac_sync #(.STAGES(SYNC_N)) i_sync_bclk  (.clk(clk), .rst(rst), .async_i(bit_clk_i),   .level_o(bclk_lvl));
  sac_sync #(.STAGES(SYNC_N)) i_sync_frame (.clk(clk), .rst(rst), .async_i(frame_clk_i), .level_o(frame_lvl));

  sac_edge #(.WARM(WARM)) i_edge_bclk  (.clk(clk), .rst(rst), .level_i(bclk_lvl),  .rise_o(bclk_rise));
  sac_edge #(.WARM(WARM)) i_edge_frame (.clk(clk), .rst(rst), .level_i(frame_lvl), .rise_o(frame_rise));

  sac_shifter #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) i_shifter (
    .clk(clk), .rst(rst), .bit_rise_i(bclk_rise), .frame_lvl_i(frame_lvl),
    .frame_rise_i(frame_rise), .din_i(data_lvl),
    .word_done_o(word_done), .top_o(top_byte)
  );

  sac_hold #(.KEEP_W(KEEP_W)) i_hold (
    .clk(clk), .rst(rst), .done_i(word_done), .byte_i(top_byte),
    .taken_i(sample_taken_i), .sample_o(sample_o), .ready_o(sample_ready_o)
  );
endmodule

// File: tb/test_serial_adc_capture.sv
`timescale 1ns/1ps
module test_serial_adc_capture;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser = 1'b0, bclk = 1'b0, lr = 1'b0, taken = 1'b0;
  logic [7:0] sample;
  logic ready;
  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  serial_adc_capture i_serial_adc_capture (
    .clk(clk), .rst(rst), .ser_data_i(ser), .bit_clk_i(bclk), .frame_clk_i(lr),
    .sample_taken_i(taken), .sample_o(sample), .sample_ready_o(ready)
  );

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_bit(input logic b);
    ser = b;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic frame(input logic [23:0] w, input int nleft, input logic [23:0] r);
    lr = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nleft; i++) pulse_bit(i < 24 ? w[23-i] : 1'b1);
    lr = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 24; i++) pulse_bit(r[23-i]);
    repeat (10) @(negedge clk);
  endtask

  task automatic take();
    @(negedge clk); taken = 1'b1;
    @(negedge clk); taken = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    expect_eq("R1 ready in reset", ready, 0);
    expect_eq("R1 sample in reset", sample, 0);
    rst = 1'b0;
    @(negedge clk);
    expect_eq("R1 ready after reset", ready, 0);
    expect_eq("R1 sample after reset", sample, 0);
  endtask

  task automatic t_no_start_edge();  // lr already high from reset
    for (int i = 0; i < 24; i++) pulse_bit(1'b1);
    repeat (10) @(negedge clk);
    expect_eq("R9 no capture without frame edge", ready, 0);
    lr = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_basic();
    frame(24'hA51234, 24, 24'h0F0F0F);
    expect_eq("R4 ready after word", ready, 1);
    expect_eq("R2 top byte", sample, 8'hA5);
    take();
    expect_eq("R6 ready cleared", ready, 0);
  endtask

  task automatic t_patterns();
    frame(24'h800000, 24, 24'hFFFFFF);
    expect_eq("R2 pattern 80", sample, 8'h80);
    take();
    frame(24'h7FFFFF, 24, 24'h000000);
    expect_eq("R2 pattern 7F", sample, 8'h7F);
    take();
    frame(24'h00FFFF, 24, 24'hFFFFFF);
    expect_eq("R2 pattern 00", sample, 8'h00);
    expect_eq("R4 ready pattern", ready, 1);
    take();
  endtask

  task automatic t_right_ignored();
    for (int i = 0; i < 24; i++) pulse_bit(1'b1);
    repeat (10) @(negedge clk);
    expect_eq("R3 ready unchanged", ready, 0);
    expect_eq("R3 sample unchanged", sample, 8'h00);
  endtask

  task automatic t_hold();
    frame(24'h3C0000, 24, 24'hAAAAAA);
    for (int i = 0; i < 24; i++) pulse_bit(i[0]);
    repeat (10) @(negedge clk);
    expect_eq("R5 sample held", sample, 8'h3C);
    expect_eq("R5 ready held", ready, 1);
    take();
  endtask

  task automatic t_overwrite();
    frame(24'h110000, 24, 24'h000000);
    frame(24'hE70000, 24, 24'h000000);
    expect_eq("R7 overwritten sample", sample, 8'hE7);
    expect_eq("R7 ready stays", ready, 1);
    take();
    expect_eq("R6 ready cleared after overwrite", ready, 0);
  endtask

  task automatic t_long();
    frame(24'h5A0000, 30, 24'h000000);
    expect_eq("R8 long slot sample", sample, 8'h5A);
    expect_eq("R8 long slot ready", ready, 1);
    take();
    repeat (20) @(negedge clk);
    expect_eq("R8 single sample only", ready, 0);
  endtask

  task automatic t_short();
    frame(24'hFF0000, 10, 24'h000000);
    expect_eq("R10 short slot no sample", ready, 0);
    frame(24'hC30000, 24, 24'h000000);
    expect_eq("R10 restart sample", sample, 8'hC3);
    expect_eq("R10 restart ready", ready, 1);
    take();
  endtask

  initial begin
    lr = 1'b1;  // held high through reset for R9
    t_reset();
    t_no_start_edge();
    t_basic();
    t_patterns();
    t_right_ignored();
    t_hold();
    t_overwrite();
    t_long();
    t_short();
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule